// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Tag Controller

This block holds the tag and state side of a parameterised set-associative cache. It accepts one read or write request per cycle, each carrying a byte address and a write flag. From the address it derives a set index and a stored tag. It compares the tag against every way of the indexed set. One cycle after acceptance it reports hit or miss and the way it used. On a miss it also reports whether a dirty line was written back. No data payload is stored; only tags, per-line flag bytes and per-line timestamps.

On a miss the block fills a line. An invalid way is taken first. When the set is full, a victim selector picks the way. Three policies are available: oldest fill (first in, first out), least recently used, or a pseudo-random pick. A free-running count of accepted requests supplies the timestamps. Writes follow write-back rules. A write hit only marks the line dirty. Memory traffic is counted when lines are filled and when dirty victims are written back.

Four running counters expose hits, misses, memory reads and memory writes. The cache size, line size, associativity and address width are parameters. The defaults are 32 KB, 16-byte lines, 4 ways and 32-bit addresses, which give 512 sets.

Top module: `cache_tag_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, every line is invalid, all four counters read zero and `rsp_valid` is low.
- R2: The set index is `(addr >> log2(LINE_BYTES)) mod sets`, and the tag is `addr >> (log2(sets) + log2(LINE_BYTES))`. The offset bits below the line size have no effect on the hit/miss result.
- R3: A request hits when some way of the indexed set is valid and holds the same tag. If several ways qualify, the lowest-numbered way is reported. `rsp_hit` and `rsp_way` appear in the cycle after acceptance.
- R4: A write hit marks the line dirty and changes neither `mem_rd_count` nor `mem_wr_count`. A read hit changes neither counter either.
- R5: A miss fills the lowest-numbered invalid way of the set, if one exists. The filled line's flag byte is cleared and then only the valid flag (bit 0) is set, so a write miss leaves the line clean. Bit 1 is the dirty flag, bit 2 is a lock flag that is never set, and bits 7..3 are zero.
- R6: With `repl_mode` 0 or 3 (oldest fill), a full set evicts the way with the smallest fill timestamp, and the lowest way wins a tie. Hits do not refresh the timestamp.
- R7: With `repl_mode` 1 (least recently used), both a hit and a fill set the line's timestamp to the current request count. A full set evicts the way with the smallest timestamp, and the lowest way wins a tie.
- R8: With `repl_mode` 2 (random), a full set evicts a way in range 0..WAYS-1 chosen by an internal pseudo-random source. An invalid way is still preferred when one exists.
- R9: Every miss adds one to `miss_count`. A read miss adds one to `mem_rd_count` and a write miss adds one to `mem_wr_count`. An evicted valid dirty line adds one more to `mem_wr_count` and raises `rsp_writeback` for that response. Every hit adds one to `hit_count`.
- R10: The request counter that supplies timestamps advances once per accepted request. A cycle with `req_valid` low changes no counter and no line, and gives no response.
- R11: `req_ready` is high from the first clock after reset release. `rsp_valid` is high exactly in the cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| repl_mode | input | 2 | Replacement policy: 0/3 oldest fill, 1 least recently used, 2 random |
| req_ready | output | 1 | Block accepts a request this cycle |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | WAY_W | Way hit or filled |
| rsp_writeback | output | 1 | The miss evicted a dirty line |
| hit_count | output | CNT_W | Total hits |
| miss_count | output | CNT_W | Total misses |
| mem_rd_count | output | CNT_W | Memory reads (fills on read miss) |
| mem_wr_count | output | CNT_W | Memory writes (fills on write miss plus dirty writebacks) |

## Verification
A corrupted tag or valid flag shows up on the next access to that set, as a wrong `rsp_hit` or `rsp_way` one cycle after acceptance. A lost or spurious dirty flag stays hidden until the line is evicted, and then appears as a wrong `rsp_writeback` and a wrong `mem_wr_count`. A wrong timestamp only shows up as a different victim way, once the set is full and under the two age-based policies. For that reason the stimulus keeps a small tag pool per set, so that sets fill, evictions happen often, and each policy is run over long mixed sequences.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  typedef enum logic [1:0] {
    REPL_FIFO     = 2'd0,
    REPL_LRU      = 2'd1,
    REPL_RAND     = 2'd2,
    REPL_FIFO_ALT = 2'd3
  } repl_e;

  // per-line flag byte layout
  localparam int FLAG_VALID = 0;
  localparam int FLAG_DIRTY = 1;
  localparam int FLAG_LOCK  = 2;

  typedef logic [7:0] line_flags_t;

endpackage

// File: rtl/ctc_way_match.sv
module ctc_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 19,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        look_en,
  input  logic [TAG_W-1:0]            look_tag,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tags,
  input  logic [WAYS-1:0]             way_valid,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);

  logic [WAYS-1:0] hit_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = way_valid[g] && (way_tags[g] == look_tag);
  end

  // lowest way has priority
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |hit_vec;

  // a correct fill never creates two valid copies of a tag in one set
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    look_en |-> $onehot0(hit_vec));

endmodule

// File: rtl/ctc_victim_sel.sv
module ctc_victim_sel
  import ctc_pkg::*;
#(
  parameter int          WAYS      = 4,
  parameter int          TS_W      = 32,
  parameter int          WAY_W     = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       advance,
  input  logic                       pick_en,
  input  repl_e                      mode,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TS_W-1:0]  way_stamps,
  output logic [WAY_W-1:0]           victim
);

  logic [15:0]      lfsr_q;
  logic [15:0]      lfsr_d;
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest_way;
  logic [TS_W-1:0]  oldest_ts;
  logic [WAY_W-1:0] rand_way;

  // x^16 + x^14 + x^13 + x^11 + 1
  always_comb begin
    lfsr_d = lfsr_q;
    if (advance) begin
      lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_d;
  end

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!any_free && !way_valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  // strict compare keeps the lowest way on equal stamps
  always_comb begin
    oldest_way = '0;
    oldest_ts  = way_stamps[0];
    for (int w = 1; w < WAYS; w++) begin
      if (way_stamps[w] < oldest_ts) begin
        oldest_way = WAY_W'(w);
        oldest_ts  = way_stamps[w];
      end
    end
  end

  assign rand_way = WAY_W'(lfsr_q % 16'(WAYS));

  always_comb begin
    if (any_free)              victim = free_way;
    else if (mode == REPL_RAND) victim = rand_way;
    else                        victim = oldest_way;
  end

  p_free_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_en && !(&way_valid)) |-> !way_valid[victim]);

  p_victim_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pick_en |-> (32'(victim) < WAYS));

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import ctc_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          LINE_BYTES  = 16,
  parameter int          CACHE_BYTES = 32768,
  parameter int          WAYS        = 4,
  parameter int          CNT_W       = 32,
  parameter int          TS_W        = 32,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1,
  localparam int         WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        repl_mode,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_writeback,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  mem_rd_count,
  output logic [CNT_W-1:0]  mem_wr_count
);

  localparam int NUM_SETS = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int SET_W    = $clog2(NUM_SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - SET_W;
  localparam int LINES    = NUM_SETS * WAYS;
  localparam int LINE_W   = $clog2(LINES);

  // ---------------- line state ----------------
  logic [TAG_W-1:0] tag_q   [LINES];
  line_flags_t      flag_q  [LINES];
  logic [TS_W-1:0]  stamp_q [LINES];
  logic [TS_W-1:0]  req_cnt_q;

  logic ready_q;
  logic accept;
  repl_e mode;

  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;
  assign mode      = repl_e'(repl_mode);

  // ---------------- address split ----------------
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [LINE_W-1:0] set_base;
  logic              unused_offset;

  assign set_idx       = req_addr[OFF_W +: SET_W];
  assign req_tag       = req_addr[ADDR_W-1 -: TAG_W];
  assign set_base      = LINE_W'(set_idx) * LINE_W'(WAYS);
  assign unused_offset = ^req_addr[OFF_W-1:0];

  // ---------------- set read ----------------
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][7:0]       rd_flags;
  logic [WAYS-1:0][TS_W-1:0]  rd_stamp;
  logic [WAYS-1:0]            rd_valid;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tag[w]   = tag_q[set_base + LINE_W'(w)];
      rd_flags[w] = flag_q[set_base + LINE_W'(w)];
      rd_stamp[w] = stamp_q[set_base + LINE_W'(w)];
      rd_valid[w] = rd_flags[w][FLAG_VALID];
    end
  end

  // ---------------- lookup and victim ----------------
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;

  ctc_way_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .WAY_W (WAY_W)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_en   (accept),
    .look_tag  (req_tag),
    .way_tags  (rd_tag),
    .way_valid (rd_valid),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  ctc_victim_sel #(
    .WAYS      (WAYS),
    .TS_W      (TS_W),
    .WAY_W     (WAY_W),
    .LFSR_SEED (LFSR_SEED)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (accept),
    .pick_en    (accept && !hit),
    .mode       (mode),
    .way_valid  (rd_valid),
    .way_stamps (rd_stamp),
    .victim     (victim)
  );

  // ---------------- next state ----------------
  logic [WAY_W-1:0]  sel_way;
  logic [LINE_W-1:0] wr_line;
  line_flags_t       sel_flags;
  line_flags_t       new_flags;
  logic              victim_dirty;
  logic              flag_we;
  logic              tag_we;
  logic              stamp_we;
  logic              miss_acc;
  logic [TS_W-1:0]   req_cnt_d;
  logic [CNT_W-1:0]  hit_cnt_d;
  logic [CNT_W-1:0]  miss_cnt_d;
  logic [CNT_W-1:0]  mem_rd_d;
  logic [CNT_W-1:0]  mem_wr_d;

  assign sel_way      = hit ? hit_way : victim;
  assign wr_line      = set_base + LINE_W'(sel_way);
  assign sel_flags    = rd_flags[sel_way];
  assign victim_dirty = sel_flags[FLAG_VALID] && sel_flags[FLAG_DIRTY];
  assign miss_acc     = accept && !hit;

  always_comb begin
    new_flags = sel_flags;
    flag_we   = accept;
    tag_we    = 1'b0;
    stamp_we  = 1'b0;
    if (hit) begin
      if (req_write) new_flags[FLAG_DIRTY] = 1'b1;
      stamp_we = accept && (mode == REPL_LRU);
    end else begin
      new_flags             = '0;
      new_flags[FLAG_VALID] = 1'b1;
      tag_we                = accept;
      stamp_we              = accept;
    end
  end

  always_comb begin
    req_cnt_d  = req_cnt_q;
    hit_cnt_d  = hit_count;
    miss_cnt_d = miss_count;
    mem_rd_d   = mem_rd_count;
    mem_wr_d   = mem_wr_count;
    if (accept) begin
      req_cnt_d = req_cnt_q + 1'b1;
      if (hit) hit_cnt_d = hit_count + 1'b1;
    end
    if (miss_acc) begin
      miss_cnt_d = miss_count + 1'b1;
      if (req_write) mem_wr_d = mem_wr_count + 1'b1 + CNT_W'(victim_dirty);
      else begin
        mem_rd_d = mem_rd_count + 1'b1;
        mem_wr_d = mem_wr_count + CNT_W'(victim_dirty);
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) flag_q[i] <= '0;
    end else if (flag_we) begin
      flag_q[wr_line] <= new_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we)   tag_q[wr_line]   <= req_tag;
    if (stamp_we) stamp_q[wr_line] <= req_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q       <= 1'b0;
      req_cnt_q     <= '0;
      hit_count     <= '0;
      miss_count    <= '0;
      mem_rd_count  <= '0;
      mem_wr_count  <= '0;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      rsp_writeback <= 1'b0;
    end else begin
      ready_q       <= 1'b1;
      req_cnt_q     <= req_cnt_d;
      hit_count     <= hit_cnt_d;
      miss_count    <= miss_cnt_d;
      mem_rd_count  <= mem_rd_d;
      mem_wr_count  <= mem_wr_d;
      rsp_valid     <= accept;
      rsp_writeback <= miss_acc && victim_dirty;
      if (accept) begin
        rsp_hit <= hit;
        rsp_way <= sel_way;
      end
    end
  end

  // ---------------- assertions ----------------
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_no_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  p_hit_no_traffic_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ($stable(mem_rd_count) && $stable(mem_wr_count)));

  p_miss_bump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (miss_count == $past(miss_count) + 1'b1));

  p_wb_on_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_writeback |-> (rsp_valid && !rsp_hit));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(hit_count) && $stable(miss_count) &&
                 $stable(mem_rd_count) && $stable(mem_wr_count)));

endmodule

// File: tb/cache_tag_ctrl_test.sv
`timescale 1ns/1ps
module cache_tag_ctrl_test;

  localparam int AW   = 16;
  localparam int LB   = 16;
  localparam int CB   = 512;
  localparam int NW   = 4;
  localparam int NS   = CB / (LB * NW);   // 8 sets
  localparam int OFFB = 4;
  localparam int SETB = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic req_write;
  logic [1:0] repl_mode;
  logic req_ready, rsp_valid, rsp_hit, rsp_writeback;
  logic [1:0] rsp_way;
  logic [31:0] hit_count, miss_count, mem_rd_count, mem_wr_count;

  always #10 clk = ~clk;

  cache_tag_ctrl #(
    .ADDR_W(AW), .LINE_BYTES(LB), .CACHE_BYTES(CB), .WAYS(NW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .repl_mode(repl_mode), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_writeback(rsp_writeback), .hit_count(hit_count), .miss_count(miss_count),
    .mem_rd_count(mem_rd_count), .mem_wr_count(mem_wr_count)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  bit          m_val [NS][NW];
  bit          m_dty [NS][NW];
  int          m_tag [NS][NW];
  int unsigned m_ts  [NS][NW];
  int unsigned m_cnt;
  int unsigned e_hit, e_miss, e_rd, e_wr;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic chk_counters(input string rq);
    chk(rq, "hit_count",    hit_count,    e_hit);
    chk(rq, "miss_count",   miss_count,   e_miss);
    chk(rq, "mem_rd_count", mem_rd_count, e_rd);
    chk(rq, "mem_wr_count", mem_wr_count, e_wr);
  endtask

  function automatic logic [AW-1:0] mk_addr(input int tag, input int set, input int off);
    return AW'((tag << (OFFB + SETB)) | (set << OFFB) | off);
  endfunction

  // called at a negative edge; returns at the next negative edge
  task automatic issue(input logic [AW-1:0] a, input bit wr, input logic [1:0] mode, input string rq);
    int s;
    int t;
    int way;
    bit hit;
    bit wb;
    bit use_dut;
    int unsigned best;
    s = (int'(a) >> OFFB) % NS;
    t = int'(a) >> (OFFB + SETB);
    way = -1;
    use_dut = 1'b0;
    for (int w = 0; w < NW; w++)
      if (way < 0 && m_val[s][w] && m_tag[s][w] == t) way = w;
    hit = (way >= 0);
    if (!hit) begin
      for (int w = 0; w < NW; w++)
        if (way < 0 && !m_val[s][w]) way = w;
      if (way < 0) begin
        if (mode == 2'd2) use_dut = 1'b1;
        else begin
          way = 0;
          best = m_ts[s][0];
          for (int w = 1; w < NW; w++)
            if (m_ts[s][w] < best) begin best = m_ts[s][w]; way = w; end
        end
      end
    end
    req_valid = 1'b1; req_addr = a; req_write = wr; repl_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
    if (use_dut) begin
      chk("R8", "random victim in range", (int'(rsp_way) < NW), 1);
      way = int'(rsp_way);
    end
    wb = !hit && m_val[s][way] && m_dty[s][way];
    if (hit) begin
      e_hit++;
      if (mode == 2'd1) m_ts[s][way] = m_cnt;
      if (wr) m_dty[s][way] = 1'b1;
    end else begin
      e_miss++;
      if (wr) e_wr++; else e_rd++;
      if (wb) e_wr++;
      m_val[s][way] = 1'b1;
      m_dty[s][way] = 1'b0;
      m_tag[s][way] = t;
      m_ts[s][way]  = m_cnt;
    end
    m_cnt++;
    chk("R11", "rsp_valid", rsp_valid, 1);
    chk(rq, "rsp_hit", rsp_hit, hit);
    chk(rq, "rsp_way", rsp_way, way);
    chk("R9", "rsp_writeback", rsp_writeback, wb);
    chk_counters("R9");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      req_valid = 1'b0;
      req_addr  = AW'($urandom);
      req_write = 1'($urandom);
      @(negedge clk);
      chk("R10", "rsp_valid while idle", rsp_valid, 0);
    end
    chk_counters("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_val[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = 0; m_ts[s][w] = 0;
      end
    m_cnt = 0; e_hit = 0; e_miss = 0; e_rd = 0; e_wr = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; repl_mode = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    chk_counters("R1");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "req_ready after reset", req_ready, 1);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk_counters("R1");

    // directed, oldest-fill policy
    issue(mk_addr(0, 0, 0), 0, 2'd0, "R5");    // cold miss -> way 0
    issue(mk_addr(0, 0, 15), 0, 2'd0, "R2");   // offset ignored -> hit
    issue(mk_addr(0, 0, 4), 1, 2'd0, "R4");    // write hit, dirty, no traffic
    issue(mk_addr(0, 1, 0), 0, 2'd0, "R2");    // other set, miss way 0
    issue(mk_addr(1, 0, 0), 0, 2'd0, "R5");
    issue(mk_addr(2, 0, 0), 1, 2'd0, "R5");    // write miss stays clean
    issue(mk_addr(3, 0, 0), 0, 2'd0, "R5");
    issue(mk_addr(0, 0, 0), 0, 2'd0, "R3");
    issue(mk_addr(4, 0, 0), 0, 2'd0, "R6");    // evict way 0 (dirty)
    issue(mk_addr(5, 0, 0), 1, 2'd3, "R6");    // evict way 1, clean
    issue(mk_addr(2, 0, 0), 0, 2'd0, "R5");    // hit; proves write-miss line exists
    issue(mk_addr(6, 0, 0), 0, 2'd0, "R5");    // evict way 2: write miss left it clean
    idle(5);

    // directed, least-recently-used policy on set 2
    for (int t = 0; t < 4; t++) issue(mk_addr(t, 2, 0), 0, 2'd1, "R7");
    issue(mk_addr(0, 2, 8), 1, 2'd1, "R7");    // refresh way 0
    issue(mk_addr(4, 2, 0), 0, 2'd1, "R7");    // evict way 1
    issue(mk_addr(5, 2, 0), 0, 2'd1, "R7");    // evict way 2
    idle(3);

    // directed, random policy on set 3
    for (int t = 0; t < 4; t++) issue(mk_addr(t, 3, 0), 1, 2'd2, "R8");
    for (int t = 4; t < 10; t++) issue(mk_addr(t, 3, 0), 0, 2'd2, "R8");

    // constrained random per policy
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 400; i++) begin
        issue(mk_addr($urandom_range(0, 6), $urandom_range(0, NS - 1), $urandom_range(0, LB - 1)),
              1'($urandom_range(0, 1)), 2'(m), "R3");
        if ($urandom_range(0, 15) == 0) idle(1);
      end
    end
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule